// File: doc/BRIEF.md
# Segment Address Check and Relocation

This block turns a segment-relative effective offset into a linear address for the execution side of a processor. It holds six cached segment entries. Each entry has a base, an inclusive limit, a two-bit descriptor privilege level, a code/data kind bit and one permission bit. A load port writes these entries. A request names one entry, an offset, an access type and the current privilege level. The block checks privilege, access rights and limit in that order. Only when every check passes does it add the base to the offset.

The result appears one clock after the request. The outcome is one of two things: a granted linear address, or a fault with a two-bit cause code and a zero address. A small controller has three states: `ST_IDLE` (no result), `ST_GRANT` (result valid, no fault) and `ST_DENY` (result valid, fault). The next state depends only on the request in the current cycle. `ST_IDLE` is taken when `req_valid` is low. `ST_GRANT` is taken on a request that passes. `ST_DENY` is taken on a request that fails. Any state can reach any other state.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, no result is valid and `res_fault`, `res_cause` and `res_linear` are 0. Every cached entry starts with base 0, limit 0, level 0, kind data and permission 0 (read-only).
- R2: `res_valid` is high in the cycle after a cycle with `req_valid` high, and low in the cycle after a cycle with `req_valid` low. Back-to-back requests each produce a result.
- R3: A request that passes all checks produces `res_cause` = 00, `res_fault` = 0 and `res_linear` = base + offset, wrapping modulo 2^ADDR_W.
- R4: The privilege cause code is 11. It is reported when `req_cpl` is numerically greater than the entry's level, where 0 is the most privileged of four levels. A request with `req_cpl` = 0 never gets this cause.
- R5: The rights cause code is 10. Access encodings are 00 read, 01 write, 10 fetch, and 11 reserved, which is always a rights violation. The kind bit is 1 for code. The permission bit means writable for data and readable for code. A rights violation is any of the following: a write to code, a write to data with permission 0, a read from code with permission 0, or a fetch from data. A request naming index 6 or 7 is a rights violation regardless of its other fields.
- R6: The limit cause code is 01. It is reported when the offset is greater than the limit. An offset equal to the limit passes.
- R7: When several checks fail, privilege is reported before rights, and rights before limit.
- R8: A faulting result has `res_fault` = 1, a nonzero `res_cause` and `res_linear` = 0. A non-faulting valid result has `res_cause` = 00. Whenever no result is granted, `res_linear` is 0.
- R9: A load with `ld_en` high writes base, limit, level, kind and permission into entry `ld_idx` at the clock edge. A load to index 6 or 7 changes no entry. A request in the same cycle as a load to the same index sees the entry's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Write one cached entry |
| ld_idx | input | 3 | Entry index to write |
| ld_base | input | 32 | Segment base to store |
| ld_limit | input | 32 | Inclusive segment limit to store |
| ld_dpl | input | 2 | Descriptor privilege level to store |
| ld_code | input | 1 | Kind bit: 1 code, 0 data |
| ld_rw | input | 1 | Permission: writable (data) or readable (code) |
| req_valid | input | 1 | Translation request |
| req_idx | input | 3 | Entry selected by the request |
| req_off | input | 32 | Effective offset |
| req_acc | input | 2 | Access type: 00 read, 01 write, 10 fetch |
| req_cpl | input | 2 | Current privilege level |
| res_valid | output | 1 | Result valid, one cycle after request |
| res_fault | output | 1 | Result is a violation |
| res_cause | output | 2 | 00 none, 01 limit, 10 rights, 11 privilege |
| res_linear | output | 32 | Linear address, 0 unless granted |

## Verification
The assertions assume that `req_valid` is held low while reset is asserted. Under that assumption, each request-to-result relation starts from the idle state. The assertions also assume that the access and privilege inputs are stable across the sampling edge. The stimulus drives all inputs only on falling edges and keeps requests off during reset. It covers the reserved access code, the unimplemented indices and offsets at and just past the limit. These cases are chosen so that every cause code and every priority pairing occurs.

// File: rtl/segx_pkg.sv
package segx_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'b00,
        CAUSE_LIMIT  = 2'b01,
        CAUSE_RIGHTS = 2'b10,
        CAUSE_PRIV   = 2'b11
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_GRANT = 2'b01,
        ST_DENY  = 2'b10
    } state_e;

endpackage

// File: rtl/seg_cache.sv
module seg_cache #(
    parameter int AW   = 32,
    parameter int PLW  = 2,
    parameter int NSEG = 6,
    parameter int IW   = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [IW-1:0]  wr_idx,
    input  logic [AW-1:0]  wr_base,
    input  logic [AW-1:0]  wr_limit,
    input  logic [PLW-1:0] wr_dpl,
    input  logic           wr_code,
    input  logic           wr_rw,
    input  logic [IW-1:0]  rd_idx,
    output logic           rd_hit,
    output logic [AW-1:0]  rd_base,
    output logic [AW-1:0]  rd_limit,
    output logic [PLW-1:0] rd_dpl,
    output logic           rd_code,
    output logic           rd_rw
);

    logic [AW-1:0]  base_q  [NSEG];
    logic [AW-1:0]  limit_q [NSEG];
    logic [PLW-1:0] dpl_q   [NSEG];
    logic           code_q  [NSEG];
    logic           rw_q    [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g]  <= '0;
                limit_q[g] <= '0;
                dpl_q[g]   <= '0;
                code_q[g]  <= 1'b0;
                rw_q[g]    <= 1'b0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                base_q[g]  <= wr_base;
                limit_q[g] <= wr_limit;
                dpl_q[g]   <= wr_dpl;
                code_q[g]  <= wr_code;
                rw_q[g]    <= wr_rw;
            end
        end
    end

    always_comb begin
        rd_hit   = 1'b0;
        rd_base  = '0;
        rd_limit = '0;
        rd_dpl   = '0;
        rd_code  = 1'b0;
        rd_rw    = 1'b0;
        for (int i = 0; i < NSEG; i++) begin
            if (rd_idx == IW'(i)) begin
                rd_hit   = 1'b1;
                rd_base  = base_q[i];
                rd_limit = limit_q[i];
                rd_dpl   = dpl_q[i];
                rd_code  = code_q[i];
                rd_rw    = rw_q[i];
            end
        end
    end

endmodule

// File: rtl/seg_check.sv
module seg_check
    import segx_pkg::*;
#(
    parameter int AW  = 32,
    parameter int PLW = 2
) (
    input  logic           hit,
    input  logic [PLW-1:0] cpl,
    input  logic [PLW-1:0] dpl,
    input  logic           code,
    input  logic           rw,
    input  logic [1:0]     acc,
    input  logic [AW-1:0]  off,
    input  logic [AW-1:0]  limit,
    output cause_e         cause
);

    logic rights_bad;

    always_comb begin
        unique case (acc_e'(acc))
            ACC_READ:  rights_bad = code && !rw;
            ACC_WRITE: rights_bad = code || !rw;
            ACC_FETCH: rights_bad = !code;
            default:   rights_bad = 1'b1;
        endcase
    end

    always_comb begin
        if (!hit) begin
            cause = CAUSE_RIGHTS;
        end else if (cpl > dpl) begin
            cause = CAUSE_PRIV;
        end else if (rights_bad) begin
            cause = CAUSE_RIGHTS;
        end else if (off > limit) begin
            cause = CAUSE_LIMIT;
        end else begin
            cause = CAUSE_NONE;
        end
    end

endmodule

// File: rtl/seg_reloc.sv
module seg_reloc #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] off,
    output logic [AW-1:0] linear
);

    assign linear = base + off;

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import segx_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int PL_W     = 2,
    parameter int NUM_SEGS = 6,
    parameter int IDX_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [ADDR_W-1:0] ld_base,
    input  logic [ADDR_W-1:0] ld_limit,
    input  logic [PL_W-1:0]   ld_dpl,
    input  logic              ld_code,
    input  logic              ld_rw,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [ADDR_W-1:0] req_off,
    input  logic [1:0]        req_acc,
    input  logic [PL_W-1:0]   req_cpl,
    output logic              res_valid,
    output logic              res_fault,
    output logic [1:0]        res_cause,
    output logic [ADDR_W-1:0] res_linear
);

    logic              e_hit;
    logic [ADDR_W-1:0] e_base;
    logic [ADDR_W-1:0] e_limit;
    logic [PL_W-1:0]   e_dpl;
    logic              e_code;
    logic              e_rw;
    cause_e            chk_cause;
    logic [ADDR_W-1:0] sum;

    state_e            state_q, state_d;
    cause_e            cause_q;
    logic [ADDR_W-1:0] linear_q;

    seg_cache #(
        .AW(ADDR_W), .PLW(PL_W), .NSEG(NUM_SEGS), .IW(IDX_W)
    ) u_cache (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ld_en), .wr_idx(ld_idx), .wr_base(ld_base), .wr_limit(ld_limit),
        .wr_dpl(ld_dpl), .wr_code(ld_code), .wr_rw(ld_rw),
        .rd_idx(req_idx), .rd_hit(e_hit), .rd_base(e_base), .rd_limit(e_limit),
        .rd_dpl(e_dpl), .rd_code(e_code), .rd_rw(e_rw)
    );

    seg_check #(.AW(ADDR_W), .PLW(PL_W)) u_check (
        .hit(e_hit), .cpl(req_cpl), .dpl(e_dpl), .code(e_code), .rw(e_rw),
        .acc(req_acc), .off(req_off), .limit(e_limit), .cause(chk_cause)
    );

    seg_reloc #(.AW(ADDR_W)) u_reloc (
        .base(e_base), .off(req_off), .linear(sum)
    );

    // next state: decided by the request alone
    always_comb begin
        state_d = ST_IDLE;
        if (req_valid) begin
            state_d = (chk_cause == CAUSE_NONE) ? ST_GRANT : ST_DENY;
        end
    end

    // state and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cause_q  <= CAUSE_NONE;
            linear_q <= '0;
        end else begin
            state_q  <= state_d;
            cause_q  <= req_valid ? chk_cause : CAUSE_NONE;
            linear_q <= (req_valid && chk_cause == CAUSE_NONE) ? sum : '0;
        end
    end

    // outputs by state
    always_comb begin
        res_valid  = 1'b0;
        res_fault  = 1'b0;
        res_cause  = CAUSE_NONE;
        res_linear = '0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_GRANT: begin
                res_valid  = 1'b1;
                res_linear = linear_q;
            end
            ST_DENY: begin
                res_valid = 1'b1;
                res_fault = 1'b1;
                res_cause = cause_q;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int ADDR_W = 32,
    parameter int PL_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_acc,
    input logic [PL_W-1:0]   req_cpl,
    input logic              res_valid,
    input logic              res_fault,
    input logic [1:0]        res_cause,
    input logic [ADDR_W-1:0] res_linear
);

    // R2
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    // R2
    idle_follows_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);

    // R4
    ring0_no_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cpl == '0) |=> (res_cause != 2'b11));

    // R5
    rsvd_acc_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_acc == 2'b11) |=> res_fault);

    // R8
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_fault |-> (res_linear == '0));

    // R8
    fault_cause_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_fault == (res_cause != 2'b00)));

    // R1
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_fault && res_cause == 2'b00 && res_linear == '0));

endmodule

bind seg_xlate_unit seg_xlate_chk #(.ADDR_W(ADDR_W), .PL_W(PL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_acc(req_acc),
    .req_cpl(req_cpl), .res_valid(res_valid), .res_fault(res_fault),
    .res_cause(res_cause), .res_linear(res_linear)
);

// File: tb/seg_xlate_unit_bench.sv
`timescale 1ns/1ps
module seg_xlate_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_idx = '0;
    logic [31:0] ld_base = '0, ld_limit = '0;
    logic [1:0]  ld_dpl = '0;
    logic        ld_code = 1'b0, ld_rw = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_idx = '0;
    logic [31:0] req_off = '0;
    logic [1:0]  req_acc = '0, req_cpl = '0;
    logic        res_valid, res_fault;
    logic [1:0]  res_cause;
    logic [31:0] res_linear;

    always #5 clk = ~clk;

    seg_xlate_unit u_seg_xlate_unit (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_base(ld_base),
        .ld_limit(ld_limit), .ld_dpl(ld_dpl), .ld_code(ld_code), .ld_rw(ld_rw),
        .req_valid(req_valid), .req_idx(req_idx), .req_off(req_off), .req_acc(req_acc),
        .req_cpl(req_cpl), .res_valid(res_valid), .res_fault(res_fault),
        .res_cause(res_cause), .res_linear(res_linear)
    );

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // behavioural model of the six entries
    logic [31:0] m_base [6];
    logic [31:0] m_limit[6];
    int          m_dpl  [6];
    bit          m_code [6];
    bit          m_rw   [6];

    bit          x_valid, x_fault;
    int          x_cause;
    logic [31:0] x_lin;

    task automatic model_reset();
        for (int i = 0; i < 6; i++) begin
            m_base[i] = '0; m_limit[i] = '0; m_dpl[i] = 0; m_code[i] = 0; m_rw[i] = 0;
        end
    endtask

    task automatic model_eval();
        int  k;
        bit  bad;
        x_valid = req_valid; x_fault = 0; x_cause = 0; x_lin = '0;
        if (!req_valid) return;
        k = int'(req_idx);
        if (k >= 6) x_cause = 2;
        else begin
            case (req_acc)
                2'b00:   bad = m_code[k] && !m_rw[k];
                2'b01:   bad = m_code[k] || !m_rw[k];
                2'b10:   bad = !m_code[k];
                default: bad = 1;
            endcase
            if (int'(req_cpl) > m_dpl[k]) x_cause = 3;
            else if (bad) x_cause = 2;
            else if (req_off > m_limit[k]) x_cause = 1;
        end
        x_fault = (x_cause != 0);
        if (!x_fault) x_lin = m_base[k] + req_off;
    endtask

    task automatic model_load();
        int k;
        if (!ld_en) return;
        k = int'(ld_idx);
        if (k >= 6) return;
        m_base[k] = ld_base; m_limit[k] = ld_limit; m_dpl[k] = int'(ld_dpl);
        m_code[k] = ld_code; m_rw[k] = ld_rw;
    endtask

    // one clock: evaluate model on current inputs, clock, compare at the falling edge
    task automatic step(input string tag);
        string t;
        model_eval();
        model_load();
        @(posedge clk);
        @(negedge clk);
        t = tag;
        if (t == "") begin
            case (x_cause)
                1: t = "R6";
                2: t = "R5";
                3: t = "R4";
                default: t = x_valid ? "R3" : "R2";
            endcase
        end
        checks++;
        if (res_valid !== x_valid || res_fault !== x_fault ||
            res_cause !== 2'(x_cause) || res_linear !== x_lin) begin
            errors++;
            $display("FAIL %s: got v=%0b f=%0b c=%0d lin=%h, expected v=%0b f=%0b c=%0d lin=%h",
                     t, res_valid, res_fault, res_cause, res_linear,
                     x_valid, x_fault, x_cause, x_lin);
        end
    endtask

    task automatic load(input int idx, input logic [31:0] b, input logic [31:0] l,
                        input int dpl, input bit code, input bit rw);
        ld_en = 1; ld_idx = 3'(idx); ld_base = b; ld_limit = l;
        ld_dpl = 2'(dpl); ld_code = code; ld_rw = rw;
    endtask

    task automatic req(input int idx, input logic [31:0] off, input int acc, input int cpl);
        req_valid = 1; req_idx = 3'(idx); req_off = off; req_acc = 2'(acc); req_cpl = 2'(cpl);
    endtask

    task automatic quiet();
        ld_en = 0; req_valid = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state at the outputs
        checks++;
        if (res_valid !== 0 || res_fault !== 0 || res_cause !== 0 || res_linear !== 0) begin
            errors++;
            $display("FAIL R1: got v=%0b f=%0b c=%0d lin=%h, expected all zero",
                     res_valid, res_fault, res_cause, res_linear);
        end
        // R1 reset entries: offset 0 reads pass, offset 1 exceeds limit 0
        for (int i = 0; i < 6; i++) begin
            quiet(); req(i, 32'h0, 0, 0); step("R1");
            quiet(); req(i, 32'h1, 0, 0); step("R1");
            quiet(); req(i, 32'h0, 1, 0); step("R1");
        end

        // R3 relocation and wrap
        quiet(); load(1, 32'h0000_1000, 32'h0000_0FFF, 0, 1, 1); step("R9");
        quiet(); req(1, 32'h10, 2, 0); step("R3");
        quiet(); load(2, 32'hFFFF_F000, 32'hFFFF_FFFF, 3, 0, 1); step("R9");
        quiet(); req(2, 32'h2000, 1, 3); step("R3");
        // R6 limit boundary
        quiet(); req(1, 32'h0FFF, 0, 0); step("R6");
        quiet(); req(1, 32'h1000, 0, 0); step("R6");
        // R4 privilege
        quiet(); req(1, 32'h0, 2, 1); step("R4");
        quiet(); req(2, 32'h0, 0, 3); step("R4");
        // R5 rights
        quiet(); req(1, 32'h0, 1, 0); step("R5");
        quiet(); load(3, 32'h8000, 32'h10, 0, 1, 0); step("R9");
        quiet(); req(3, 32'h0, 0, 0); step("R5");
        quiet(); req(3, 32'h0, 2, 0); step("R5");
        quiet(); req(0, 32'h0, 1, 0); step("R5");
        quiet(); req(2, 32'h0, 2, 0); step("R5");
        quiet(); req(2, 32'h0, 3, 0); step("R5");
        quiet(); req(6, 32'h0, 0, 0); step("R5");
        quiet(); req(7, 32'h0, 2, 3); step("R5");
        // R7 priority
        quiet(); req(3, 32'h100, 0, 2); step("R7");
        quiet(); req(3, 32'h100, 0, 0); step("R7");
        quiet(); req(3, 32'h100, 2, 0); step("R7");
        // R9 load to index 6 ignored, entries intact
        quiet(); load(6, 32'hDEAD_0000, 32'hFFFF_FFFF, 3, 0, 1); step("R9");
        for (int i = 0; i < 6; i++) begin
            quiet(); req(i, 32'h0, 2, 0); step("R9");
        end
        // R9 same-cycle load and request sees old entry, next cycle sees new
        quiet(); load(4, 32'h0004_0000, 32'hFF, 0, 0, 1); req(4, 32'h8, 0, 0); step("R9");
        quiet(); req(4, 32'h8, 0, 0); step("R9");
        // R2 back-to-back then gaps
        for (int i = 0; i < 8; i++) begin
            quiet(); if (i % 3 != 2) req(i % 6, 32'(i), i % 3, 0); step("R2");
        end
        // mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            quiet();
            if ($urandom_range(0, 3) == 0)
                load(int'($urandom_range(0, 7)), $urandom, 32'($urandom_range(0, 65535)),
                     int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)),
                     bit'($urandom_range(0, 1)));
            if ($urandom_range(0, 3) != 0)
                req(int'($urandom_range(0, 7)), 32'($urandom_range(0, 70000)),
                    int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
            step("");
        end
        quiet(); step("R2");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule